// File: doc/BRIEF.md
# Transmit/Receive Byte Queue Pair with Occupancy Interrupts

This block holds two independent byte queues that sit between a register bus and a serial shifter. The transmit queue is filled by the bus and drained by the shifter. The receive queue is filled by the shifter and drained by the bus. Both queues run on one clock. Each one has a push port and a pop port, and data leaves each queue in the order it entered. Popped data appears on a registered read-data output one cycle after the pop.

The block turns queue occupancy into interrupt and status outputs:

- The receive interrupt is raised whenever the receive queue holds data.
- The transmit interrupt follows one configuration input. With that input high, the interrupt marks a completely drained queue, so it can act as a "message sent" signal. With that input low, it marks a queue that is half drained or less full.
- A transmit-full flag lets software stop writing before the queue overruns.

Misuse is handled safely. A push that cannot be stored is dropped and latches an overflow flag. A pop from an empty queue changes nothing.

Top module: `byte_fifo_pair`

## Requirements
- R1: Each queue stores up to DEPTH bytes (default 32). DEPTH pushes into an empty queue, with no pops, are all accepted and come back out unaltered.
- R2: Bytes leave a queue in push order. The byte removed by a pop appears on that queue's read-data output one clock after the pop and stays there until the next accepted pop.
- R3: rx_irq is 1 exactly when the receive queue holds one byte or more.
- R4: With tx_irq_on_empty = 1, tx_irq is 1 exactly when the transmit queue holds zero bytes.
- R5: With tx_irq_on_empty = 0, tx_irq is 1 exactly when the transmit queue holds DEPTH/2 (16) bytes or fewer.
- R6: While rst_n is low (asynchronous, active low), and right after it rises, both queues are empty. tx_irq is 1 in either mode, and rx_irq, tx_full, tx_ovf and rx_ovf are 0. Both read-data outputs are 0.
- R7: tx_full is 1 exactly when the transmit queue holds DEPTH bytes. tx_empty is 1 exactly when it holds zero bytes.
- R8: A push into a full queue in a cycle with no pop is dropped. The stored contents are unchanged, and that queue's overflow flag (tx_ovf or rx_ovf) becomes 1 on the next clock. The flag stays 1 until reset.
- R9: A pop on an empty queue leaves the read-data output, the occupancy and all flags unchanged.
- R10: A push and a pop in the same cycle on a non-empty queue, including a full one, are both accepted and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both queues |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_irq_on_empty | input | 1 | Transmit interrupt mode: 1 = queue empty, 0 = half drained |
| tx_push | input | 1 | Write one byte into the transmit queue |
| tx_wdata | input | 8 | Byte to write into the transmit queue |
| tx_pop | input | 1 | Remove the oldest byte from the transmit queue |
| tx_rdata | output | 8 | Last byte removed from the transmit queue |
| tx_irq | output | 1 | Transmit threshold interrupt |
| tx_full | output | 1 | Transmit queue is full |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_push | input | 1 | Write one byte into the receive queue |
| rx_wdata | input | 8 | Byte to write into the receive queue |
| rx_pop | input | 1 | Remove the oldest byte from the receive queue |
| rx_rdata | output | 8 | Last byte removed from the receive queue |
| rx_irq | output | 1 | Receive data-available interrupt |
| rx_ovf | output | 1 | Sticky receive overflow flag |

## Verification
A wrong occupancy count shows up at once, in the same cycle, on the combinational flags. tx_irq, tx_full, tx_empty and rx_irq all decode the count, so a count that is off by one is visible on the cycle that crosses 0, 16 or 32. A pointer that slips without a count error leaves the flags correct. It only appears on read data, one cycle after the pop that reads the wrong slot. For that reason the bench compares every popped byte against its own ordered model. Overflow handling is visible one cycle after the dropped push, on the sticky flag. Any damage it does to stored data surfaces when that part of the queue is later drained.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  // Next occupancy from the accepted handshakes of one cycle.
  function automatic int unsigned occ_next(int unsigned occ, logic push_ok, logic pop_ok);
    return occ + int'(push_ok) - int'(pop_ok);
  endfunction

  // Transmit interrupt threshold: empty, or at most half of the depth.
  function automatic logic tx_thresh_hit(int unsigned occ, int unsigned depth, logic on_empty);
    return on_empty ? (occ == 0) : (occ <= depth / 2);
  endfunction

  // Circular pointer advance for a depth that need not be a power of two.
  function automatic int unsigned ptr_next(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/bfp_fifo.sv
module bfp_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          push_drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign pop_acc   = pop && !empty;
  assign push_acc  = push && (!full || pop_acc);
  assign push_drop = push && !push_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_acc) wr_ptr <= AW'(bfp_pkg::ptr_next(int'(wr_ptr), DEPTH));
      if (pop_acc) begin
        rd_ptr <= AW'(bfp_pkg::ptr_next(int'(rd_ptr), DEPTH));
        rdata  <= mem[rd_ptr];
      end
      count <= CW'(bfp_pkg::occ_next(int'(count), push_acc, pop_acc));
      if (push_drop) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/bfp_tx_irq.sv
module bfp_tx_irq #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          on_empty,
  output logic          irq
);
  always_comb irq = bfp_pkg::tx_thresh_hit(int'(count), DEPTH, on_empty);
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_irq_on_empty,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  output logic          tx_irq,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          tx_ovf,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_irq,
  output logic          rx_ovf
);
  logic [CW-1:0] tx_count, rx_count;
  logic tx_push_acc, tx_pop_acc, tx_push_drop;
  logic rx_push_acc, rx_pop_acc, rx_push_drop;
  logic rx_full, rx_empty;

  bfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .push_acc(tx_push_acc), .pop_acc(tx_pop_acc),
    .push_drop(tx_push_drop)
  );

  bfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .push_acc(rx_push_acc), .pop_acc(rx_pop_acc),
    .push_drop(rx_push_drop)
  );

  bfp_tx_irq #(.DEPTH(DEPTH)) u_tx_irq (
    .count(tx_count), .on_empty(tx_irq_on_empty), .irq(tx_irq)
  );

  assign rx_irq = !rx_empty;
endmodule

// File: rtl/bfp_chk.sv
module bfp_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_irq_on_empty,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [DW-1:0] tx_rdata,
  input logic          tx_irq,
  input logic          tx_full,
  input logic          tx_empty,
  input logic          tx_ovf,
  input logic          tx_push_drop,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [DW-1:0] rx_rdata,
  input logic          rx_irq,
  input logic          rx_ovf
);
  int unsigned tx_m, rx_m;
  logic tx_pop_ok, rx_pop_ok, tx_push_ok, rx_push_ok;

  // Occupancy rebuilt from the port handshakes only.
  assign tx_pop_ok  = tx_pop && (tx_m != 0);
  assign rx_pop_ok  = rx_pop && (rx_m != 0);
  assign tx_push_ok = tx_push && ((tx_m < DEPTH) || tx_pop_ok);
  assign rx_push_ok = rx_push && ((rx_m < DEPTH) || rx_pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_m <= 0;
      rx_m <= 0;
    end else begin
      tx_m <= tx_m + int'(tx_push_ok) - int'(tx_pop_ok);
      rx_m <= rx_m + int'(rx_push_ok) - int'(rx_pop_ok);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_VALUES: assert (tx_irq && !rx_irq && !tx_full && !tx_ovf && !rx_ovf) else $error("reset values"); // R6
    end
  end

  AST_RX_IRQ_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (rx_m != 0)); // R3
  AST_TX_IRQ_EMPTY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_on_empty |-> (tx_irq == (tx_m == 0))); // R4
  AST_TX_IRQ_HALF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq_on_empty |-> (tx_irq == (tx_m <= DEPTH / 2))); // R5
  AST_TX_FULL_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full == (tx_m == DEPTH)); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_push && !tx_pop |=> tx_ovf); // R8
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_drop |-> tx_full); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R8
  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty && tx_pop && !tx_push |=> $stable(tx_rdata) && tx_empty); // R9
  AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_irq && rx_pop && !rx_push |=> $stable(rx_rdata) && !rx_irq); // R9
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty && tx_push && tx_pop |=> $stable(tx_full) && !tx_empty); // R10
endmodule

bind byte_fifo_pair bfp_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_irq_on_empty(tx_irq_on_empty),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_irq(tx_irq),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf),
  .tx_push_drop(tx_push_drop), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_rdata(rx_rdata), .rx_irq(rx_irq), .rx_ovf(rx_ovf)
);

// File: tb/byte_fifo_pair_tb.sv
`timescale 1ns/1ps
module byte_fifo_pair_tb;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [7:0] tx_rdata, rx_rdata;
  logic tx_irq, tx_full, tx_empty, tx_ovf, rx_irq, rx_ovf;

  int errors = 0;
  int checks = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] exp_tx_rd = '0, exp_rx_rd = '0;
  logic exp_tx_ovf = 1'b0, exp_rx_ovf = 1'b0;

  always #5 clk = ~clk;

  byte_fifo_pair u_dut (
    .clk(clk), .rst_n(rst_n), .tx_irq_on_empty(mode),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_irq(tx_irq), .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_irq(rx_irq), .rx_ovf(rx_ovf)
  );

  function automatic logic exp_tx_irq(int n, logic m);
    if (m) return n == 0;
    return 2 * n <= DEPTH;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 tx_rdata", tx_rdata, exp_tx_rd);
    chk("R2 rx_rdata", rx_rdata, exp_rx_rd);
    chk("R3 rx_irq", {7'd0, rx_irq}, {7'd0, rxq.size() != 0});
    chk(mode ? "R4 tx_irq" : "R5 tx_irq", {7'd0, tx_irq}, {7'd0, exp_tx_irq(txq.size(), mode)});
    chk("R7 tx_full", {7'd0, tx_full}, {7'd0, txq.size() == DEPTH});
    chk("R7 tx_empty", {7'd0, tx_empty}, {7'd0, txq.size() == 0});
    chk("R8 tx_ovf", {7'd0, tx_ovf}, {7'd0, exp_tx_ovf});
    chk("R8 rx_ovf", {7'd0, rx_ovf}, {7'd0, exp_rx_ovf});
  endtask

  task automatic step(logic tp, logic [7:0] td, logic tq, logic rp, logic [7:0] rd, logic rq);
    logic tpop_ok, rpop_ok;
    @(negedge clk);
    tx_push = tp; tx_wdata = td; tx_pop = tq;
    rx_push = rp; rx_wdata = rd; rx_pop = rq;
    @(posedge clk);
    #1;
    tpop_ok = tq && txq.size() != 0;
    rpop_ok = rq && rxq.size() != 0;
    if (tpop_ok) exp_tx_rd = txq.pop_front();
    if (rpop_ok) exp_rx_rd = rxq.pop_front();
    if (tp) begin
      if (txq.size() < DEPTH) txq.push_back(td);
      else exp_tx_ovf = 1'b1;
    end
    if (rp) begin
      if (rxq.size() < DEPTH) rxq.push_back(rd);
      else exp_rx_ovf = 1'b1;
    end
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    rst_n = 1'b0;
    #3;
    txq.delete(); rxq.delete();
    exp_tx_rd = '0; exp_rx_rd = '0; exp_tx_ovf = 0; exp_rx_ovf = 0;
    // R6: values while reset is held, in both interrupt modes
    mode = 1'b0; #1; chk("R6 tx_irq half mode in reset", {7'd0, tx_irq}, 8'd1);
    mode = 1'b1; #1; chk("R6 tx_irq empty mode in reset", {7'd0, tx_irq}, 8'd1);
    check_all();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all(); // R6 after release
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R1 / R7 / R4: fill the transmit queue in empty mode.
    mode = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'hA0 + i), 0, 1, 8'(8'h40 + i), 0);
    // R8: a push into each full queue with no pop is dropped.
    step(1, 8'hEE, 0, 1, 8'hDD, 0);
    // R10: push and pop together on a full queue.
    step(1, 8'h77, 1, 1, 8'h66, 1);
    // R5: switch to half mode and drain across the threshold.
    mode = 1'b0;
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 1);
    // R9: pop on empty queues changes nothing.
    step(0, 0, 1, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1);
    // R10: push and pop together with one byte held.
    step(1, 8'h11, 0, 1, 8'h22, 0);
    step(1, 8'h33, 1, 1, 8'h44, 1);
    step(0, 0, 1, 0, 0, 1);

    // Random traffic in phases with a shifting fill bias.
    for (int ph = 0; ph < 8; ph++) begin
      int pp = (ph % 2 == 0) ? 70 : 30;
      mode = ph[1];
      for (int c = 0; c < 400; c++) begin
        step(($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < (100 - pp),
             ($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < (100 - pp));
      end
    end

    // R6: reset in the middle of traffic clears the queues and the flags.
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(i), 0, 1, 8'(i), 0);
    do_reset();
    step(0, 0, 1, 0, 0, 1);
    summary();
  end
endmodule